// File: doc/BRIEF.md
# Open-Drain Byte Shifter

This block moves one byte at a time over a single bidirectional data line shared, wired-AND, with other devices. A serial clock paces the transfer. The host offers a byte on a valid/ready write port. Once the unit accepts it, the unit sends that byte most significant bit first and collects a byte from the same line. It stops after eight clock periods and raises a sticky completion flag. The clock can come from an internal divider, which makes exactly eight pulses, or from an external source that the unit only observes.

The data pad is open-drain. The unit can only pull the line low, and a pull-up holds it high otherwise. To receive without disturbing the line, the host sends all-ones. The line follows a separate output latch. Between transfers, two strobe inputs can force that latch high or low, which lets the host build start and stop conditions on the bus.

The write port is the only stream interface. `wr_ready` is high exactly when no transfer is running. A byte transfers on a cycle where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the host must hold its byte and wait, and offers made then have no effect.

Top module: `od_serial_shifter`

## Requirements
- R1: Bits leave MSB first. After the first falling clock edge of a transfer, the line carries bit 7 of the written byte. After the transfer ends, the latch keeps bit 0.
- R2: The output latch changes only on falling clock edges. Received bits enter the shift register only on rising edges, at bit 0, while the contents move toward bit 7.
- R3: The eighth rising edge ends the transfer. The completion flag `xfer_done` rises and `wr_ready` returns to 1 on the same cycle. After seven rising edges the transfer is still running.
- R4: `sda_pull_low` is 1 exactly when the output latch holds 0. When the unit sends FFh, the received byte equals the bits that other devices drive on the line.
- R5: While idle, a `cmd_line` strobe clears the latch (line pulled low) and a `rel_line` strobe sets it (line released). When both strobes are high together, the clear wins.
- R6: `rel_line` and `cmd_line` have no effect while a transfer is running.
- R7: A write is accepted only when `wr_valid` and `wr_ready` are both high. The next cycle `wr_ready` is 0, and offers made during a transfer change nothing.
- R8: With `ext_mode`=0, each transfer produces exactly eight clock pulses on `sck_o`. Each half period lasts `half_cycles` clock cycles (0 is treated as 1), the idle level is high, and `sck_oe`=1. With `ext_mode`=1, `sck_oe`=0.
- R9: `xfer_done` stays set until a `flag_clr` strobe. A completion on the same cycle as a clear leaves the flag set.
- R10: After reset: `wr_ready`=1, `xfer_done`=0, `sda_pull_low`=0, `sck_o`=1.
- R11: In external-clock mode, edges on `sck_in` while idle start nothing and change neither the latch nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | 1: serial clock taken from `sck_in`; 0: internal divider |
| half_cycles | input | DIV_W | Internal clock half period in system cycles |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Unit idle, byte will be taken |
| wr_data | input | DATA_W | Byte to send (FFh to only receive) |
| rel_line | input | 1 | Idle strobe: set output latch |
| cmd_line | input | 1 | Idle strobe: clear output latch |
| flag_clr | input | 1 | Clears the completion flag |
| xfer_done | output | 1 | Sticky completion flag |
| rx_data | output | DATA_W | Shift register contents, the received byte once done |
| sda_pull_low | output | 1 | Open-drain enable: pull data line low |
| sda_in | input | 1 | Sample of the data line |
| sck_o | output | 1 | Internal clock level to drive |
| sck_oe | output | 1 | Clock pad drive enable |
| sck_in | input | 1 | Sample of the clock line |

## Verification
The bench stops an externally clocked transfer between the eighth falling edge and the eighth rising edge. At that point the shift register must hold the partly shifted value and the flag must still be low. A design that sampled on the wrong edge, or counted one pulse too few, shows a different value there. The bench strobes the latch controls and offers a new byte in the middle of a transfer. A design that honoured either would change the line level or the received byte. The bench counts clock pulses for several divider settings against peers that pull bits low, which exposes an extra or missing pulse and errors in the wired-AND receive path. Clock edges while idle in external mode must leave the unit idle.

// File: rtl/ods_pkg.sv
package ods_pkg;
  localparam int BYTE_BITS = 8;
  localparam int PHASES_PER_BIT = 2;
endpackage

// File: rtl/ods_sck_divider.sv
module ods_sck_divider #(
  parameter int DIV_W  = 8,
  parameter int PULSES = ods_pkg::BYTE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_cycles,
  output logic             sck_gen
);
  localparam int TOGGLES = PULSES * ods_pkg::PHASES_PER_BIT;
  localparam int PH_W    = $clog2(TOGGLES);

  logic             run;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  ph;
  logic [DIV_W-1:0] lim;

  assign lim = (half_cycles == '0) ? DIV_W'(1) : half_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      ph      <= '0;
      sck_gen <= 1'b1;
    end else if (start) begin
      run     <= 1'b1;
      cnt     <= '0;
      ph      <= '0;
      sck_gen <= 1'b1;
    end else if (run) begin
      if (cnt == lim - DIV_W'(1)) begin
        cnt     <= '0;
        sck_gen <= ~sck_gen;
        if (ph == PH_W'(TOGGLES - 1)) run <= 1'b0;
        else                          ph  <= ph + PH_W'(1);
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ods_shift_engine.sv
module ods_shift_engine #(
  parameter int DATA_W = ods_pkg::BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall,
  input  logic              rise,
  input  logic              line_in,
  input  logic              rel,
  input  logic              cmd,
  input  logic              flag_clr,
  output logic              busy,
  output logic              flag,
  output logic [DATA_W-1:0] shreg,
  output logic              latch
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] bit_cnt;
  logic             last_rise;

  assign last_rise = busy && rise && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '0;
      latch   <= 1'b1;
      bit_cnt <= '0;
    end else if (!busy) begin
      if (load) begin
        shreg   <= load_data;
        busy    <= 1'b1;
        bit_cnt <= '0;
      end else if (cmd) begin
        latch <= 1'b0;
      end else if (rel) begin
        latch <= 1'b1;
      end
    end else begin
      if (fall) latch <= shreg[DATA_W-1];
      if (rise) begin
        shreg   <= {shreg[DATA_W-2:0], line_in};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (last_rise) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (last_rise) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/od_serial_shifter.sv
module od_serial_shifter #(
  parameter int DATA_W = ods_pkg::BYTE_BITS,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [DIV_W-1:0]  half_cycles,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rel_line,
  input  logic              cmd_line,
  input  logic              flag_clr,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sda_pull_low,
  input  logic              sda_in,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_in
);
  logic busy, latch, load, sck_gen, sck_cur, sck_prev, fall, rise;

  assign load    = wr_valid && !busy;
  assign sck_cur = ext_mode ? sck_in : sck_gen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b1;
    else        sck_prev <= sck_cur;
  end

  assign fall = sck_prev && !sck_cur;
  assign rise = !sck_prev && sck_cur;

  ods_sck_divider #(.DIV_W(DIV_W), .PULSES(DATA_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(load && !ext_mode),
    .half_cycles(half_cycles), .sck_gen(sck_gen)
  );

  ods_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .fall(fall), .rise(rise), .line_in(sda_in),
    .rel(rel_line), .cmd(cmd_line), .flag_clr(flag_clr),
    .busy(busy), .flag(xfer_done), .shreg(rx_data), .latch(latch)
  );

  assign wr_ready     = !busy;
  assign sda_pull_low = !latch;
  assign sck_o        = sck_gen;
  assign sck_oe       = !ext_mode;
endmodule

// File: rtl/ods_checker.sv
module ods_checker (
  input logic clk,
  input logic rst_n,
  input logic ext_mode,
  input logic wr_valid,
  input logic wr_ready,
  input logic xfer_done,
  input logic flag_clr,
  input logic sck_o,
  input logic sda_pull_low
);
  logic sck_d, fell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b1;
      fell_q <= 1'b0;
    end else begin
      sck_d  <= sck_o;
      fell_q <= sck_d && !sck_o;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !flag_clr) |=> xfer_done);

  assert_done_with_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> $rose(wr_ready));

  assert_idle_clock_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !ext_mode) |-> sck_o);

  assert_latch_on_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !wr_ready && $past(!wr_ready) && !fell_q) |-> $stable(sda_pull_low));

  assert_accept_then_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
endmodule

bind od_serial_shifter ods_checker u_chk (.*);

// File: tb/od_serial_shifter_tb.sv
module od_serial_shifter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ext_mode, wr_valid, rel_line, cmd_line, flag_clr, bench_sck;
  logic [7:0] half_cycles, wr_data;
  logic wr_ready, xfer_done, sda_pull_low, sck_o, sck_oe;
  logic [7:0] rx_data;
  logic peer_pull, peer_active, sda_line, sck_line;
  logic [7:0] peer_byte, obs;
  int peer_idx, falls, n_chk, n_bad;
  bit finished;

  assign sda_line = !(sda_pull_low || peer_pull);
  assign sck_line = ext_mode ? bench_sck : (sck_oe ? sck_o : 1'b1);

  od_serial_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .half_cycles(half_cycles),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rel_line(rel_line), .cmd_line(cmd_line), .flag_clr(flag_clr),
    .xfer_done(xfer_done), .rx_data(rx_data), .sda_pull_low(sda_pull_low),
    .sda_in(sda_line), .sck_o(sck_o), .sck_oe(sck_oe), .sck_in(sck_line)
  );

  always @(negedge sck_line) begin
    falls = falls + 1;
    if (peer_active && peer_idx < 8) begin
      peer_pull = !peer_byte[7 - peer_idx];
      peer_idx  = peer_idx + 1;
    end
  end

  always @(posedge sck_line) if (peer_active) obs = {obs[6:0], sda_line};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_data = b; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic strobe(input bit rel, input bit cmd);
    @(negedge clk); rel_line = rel; cmd_line = cmd;
    @(negedge clk); rel_line = 1'b0; cmd_line = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_edge(input logic lvl);
    @(negedge clk); bench_sck = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // {tx byte, peer byte, half period}
  localparam logic [23:0] VEC [6] = '{
    {8'hA5, 8'hFF, 8'd1}, {8'hFF, 8'h3C, 8'd2}, {8'h00, 8'hFF, 8'd1},
    {8'hFF, 8'hFF, 8'd3}, {8'h81, 8'h7E, 8'd0}, {8'h5A, 8'hC3, 8'd4}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; ext_mode = 1'b0; wr_valid = 1'b0; rel_line = 1'b0;
    cmd_line = 1'b0; flag_clr = 1'b0; bench_sck = 1'b1; half_cycles = 8'd1;
    wr_data = 8'h00; peer_pull = 1'b0; peer_active = 1'b0; peer_byte = 8'hFF;
    obs = 8'h00; peer_idx = 0; falls = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 ready", wr_ready, 1); check("R10 flag", xfer_done, 0);
    check("R10 pull", sda_pull_low, 0); check("R10 sck", sck_o, 1);
    check("R8 oe internal", sck_oe, 1);

    // vector walk, internal clock
    for (int i = 0; i < 6; i++) begin
      logic [7:0] tx, pr, hc;
      {tx, pr, hc} = VEC[i];
      half_cycles = hc; peer_byte = pr; peer_idx = 0; obs = 8'h00; falls = 0;
      peer_active = 1'b1;
      write_byte(tx);
      check("R7 busy after accept", wr_ready, 0);
      for (int w = 0; w < 400 && !xfer_done; w++) @(negedge clk);
      peer_active = 1'b0; peer_pull = 1'b0;
      check("R3 done", xfer_done, 1); check("R3 ready", wr_ready, 1);
      check("R4 rx wired-AND", rx_data, tx & pr);
      check("R1 line order", obs, tx & pr);
      check("R8 pulse count", falls, 8); check("R8 idle high", sck_o, 1);
      check("R1 latch keeps D0", sda_pull_low, !tx[0]);
      repeat (4) @(negedge clk);
      check("R9 sticky", xfer_done, 1);
      clear_flag();
      check("R9 cleared", xfer_done, 0);
    end

    // R5 idle latch control
    strobe(1'b0, 1'b1); check("R5 cmd pulls low", sda_pull_low, 1);
    strobe(1'b1, 1'b0); check("R5 rel releases", sda_pull_low, 0);
    strobe(1'b1, 1'b1); check("R5 cmd wins", sda_pull_low, 1);
    strobe(1'b1, 1'b0);

    // R11 external mode, idle edges ignored
    ext_mode = 1'b1;
    @(negedge clk); check("R8 oe external", sck_oe, 0);
    for (int k = 0; k < 3; k++) begin ext_edge(1'b0); ext_edge(1'b1); end
    check("R11 still idle", wr_ready, 1); check("R11 no flag", xfer_done, 0);
    check("R11 latch kept", sda_pull_low, 0);

    // external transfer of 45h, peer released
    write_byte(8'h45);
    ext_edge(1'b0);
    check("R1 first bit D7", sda_pull_low, 1);
    strobe(1'b1, 1'b0);
    check("R6 rel ignored busy", sda_pull_low, 1);
    write_byte(8'hFF);
    ext_edge(1'b1);
    for (int k = 1; k < 7; k++) begin ext_edge(1'b0); ext_edge(1'b1); end
    check("R3 not done after 7", xfer_done, 0); check("R3 busy after 7", wr_ready, 0);
    ext_edge(1'b0);
    check("R2 no capture on fall", rx_data, 8'hA2);
    ext_edge(1'b1);
    check("R3 done after 8", xfer_done, 1);
    check("R7 busy write ignored", rx_data, 8'h45);
    strobe(1'b0, 1'b1);
    check("R5 cmd after done", sda_pull_low, 1);
    strobe(1'b1, 1'b0);
    clear_flag();
    check("R9 clear ext", xfer_done, 0);
    finish_run();
  end
endmodule